// File: doc/BRIEF.md
# Five-level third-order delta-sigma modulator

This block turns a stream of 18-bit signed audio samples, one channel, delivered at eight times the audio rate, into a five-level noise-shaped code stream. It runs at the modulator rate: a clock enable `tick_i` marks each modulator step. A new sample is captured when its strobe arrives, but it is only applied at the start of the next frame. A frame lasts 6 ticks when the system clock is 384 times the audio rate, giving 48 times the audio rate at the output. It lasts 8 ticks when the system clock is 256 times the audio rate, giving 64 times. The applied sample is held for the whole frame.

The loop has three integrators in cascade. Each integrator has a register delay, and each one saturates instead of wrapping. Only the first integrator sees the input minus the quantised feedback. The quantiser input is a weighted sum of the three integrator states. All weights are sums of powers of two, chosen so that the noise transfer function has a triple pole at z = 0.5. A mute input forces mid-scale codes and clears the integrators.

Top module: `dsm5_mod`

## Requirements
- R1: While `rst_ni` is low, `level_o` is 2 and `level_valid_o` is 0. Reset also zeroes the integrators, the frame phase and both sample registers.
- R2: `level_valid_o` is 1 in the cycle after each cycle with `tick_i` high, and 0 otherwise. `level_o` changes only in the cycle after a tick.
- R3: The code produced on a tick comes from the loop sum u taken before that tick's update, with Q = 65536:
  - u >= 98304 gives 4;
  - 32768 <= u < 98304 gives 3;
  - -32768 <= u < 32768 gives 2;
  - -98304 <= u < -32768 gives 1;
  - u < -98304 gives 0.
- R4: The feedback value is (code - 2) * Q. On each unmuted tick, the first integrator adds the applied sample minus the feedback. With a zero input from reset, every code is 2.
- R5: On each unmuted tick, the second integrator adds the old first state and the third adds the old second state. The loop sum is u = s1 + s1/2 + s2/2 + s2/4 + s3/8, where each division is an arithmetic right shift.
- R6: Each integrator is a 24-bit signed register. It clamps at 8388607 and -8388608 instead of wrapping.
- R7: The sample strobe loads a pending register. On the tick at frame phase 0, the pending value is used directly and is copied to the held register. On the other ticks of the frame, the held value is used.
- R8: The frame phase counts ticks and wraps after 6 ticks when `ratio_384_i` is 1, and after 8 ticks when it is 0. If the phase is already at or past the last position on a tick, it returns to 0.
- R9: On a tick with `mute_i` high, the code is 2 and all three integrators become 0. The frame phase and the sample registers continue as normal.
- R10: Over 384 unmuted ticks from cleared integrators with a constant held input x, the sum of (code - 2) stays within 8 of 384 * x / Q for |x| <= Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 18 | Signed input sample |
| sample_valid_i | input | 1 | Sample strobe, loads the pending register |
| tick_i | input | 1 | Modulator clock enable, one loop step per high cycle |
| ratio_384_i | input | 1 | 1: 6 ticks per frame, 0: 8 ticks per frame |
| mute_i | input | 1 | Forces code 2 and clears the integrators |
| level_o | output | 3 | Quantised level code, 0 to 4 |
| level_valid_o | output | 1 | High for one cycle after each tick |

## Verification
The bench measures how many ticks pass between a sample strobe and the first code that is not mid-scale, for both frame lengths. A design that applied the sample at once, or that counted the wrong frame length, shifts that count. A loop sum that lands exactly on the upper threshold must give code 4, so a comparison of the wrong strictness shows up as a 3. A full-scale negative input drives the second and third integrators into their limits. A version that wraps flips the sign of the loop sum and its codes leave the reference. Mute is entered right after integrators have been loaded, and density is checked across both polarities. A mute that fails to clear, or a feedback value with the wrong scale or sign, skews the code sum.

// File: rtl/dsm5_pkg.sv
package dsm5_pkg;
  localparam int unsigned DSM_DW = 18;
  localparam int unsigned DSM_IW = 24;
  localparam int unsigned DSM_LW = 3;

  typedef enum logic [DSM_LW-1:0] {
    LVL_M2 = 3'd0,
    LVL_M1 = 3'd1,
    LVL_Z  = 3'd2,
    LVL_P1 = 3'd3,
    LVL_P2 = 3'd4
  } level_e;
endpackage

// File: rtl/dsm5_frame.sv
module dsm5_frame #(
  parameter int unsigned DW       = 18,
  parameter int unsigned TICKS_HI = 8,
  parameter int unsigned TICKS_LO = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] sample_i,
  input  logic                 sample_valid_i,
  input  logic                 tick_i,
  input  logic                 ratio_384_i,
  output logic signed [DW-1:0] x_o
);
  localparam int unsigned PW = $clog2(TICKS_HI);
  localparam logic [PW-1:0] LAST_HI = PW'(TICKS_HI - 1);
  localparam logic [PW-1:0] LAST_LO = PW'(TICKS_LO - 1);

  logic [PW-1:0]        phase_q;
  logic [PW-1:0]        last_w;
  logic signed [DW-1:0] pend_q, act_q;

  assign last_w = ratio_384_i ? LAST_LO : LAST_HI;
  // frame start uses the pending word directly
  assign x_o = (phase_q == '0) ? pend_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pend_q  <= '0;
      act_q   <= '0;
    end else begin
      if (tick_i) begin
        phase_q <= (phase_q >= last_w) ? '0 : phase_q + 1'b1;
        if (phase_q == '0) act_q <= pend_q;
      end
      if (sample_valid_i) pend_q <= sample_i;
    end
  end

  p_act_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && phase_q != '0) |=> $stable(act_q));
endmodule

// File: rtl/dsm5_quant.sv
module dsm5_quant
  import dsm5_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned UW = 27
) (
  input  logic signed [UW-1:0] u_i,
  output logic [DSM_LW-1:0]    code_o,
  output logic signed [DW:0]   fb_o
);
  localparam int QV = 1 << (DW - 2);
  localparam logic signed [UW-1:0] T_P1 = UW'(QV / 2);
  localparam logic signed [UW-1:0] T_P2 = UW'(3 * QV / 2);
  localparam logic signed [UW-1:0] T_M1 = -T_P1;
  localparam logic signed [UW-1:0] T_M2 = -T_P2;
  localparam logic signed [DW:0]   FQ   = (DW+1)'(QV);

  level_e lvl;

  always_comb begin
    if (u_i >= T_P2)      lvl = LVL_P2;
    else if (u_i >= T_P1) lvl = LVL_P1;
    else if (u_i >= T_M1) lvl = LVL_Z;
    else if (u_i >= T_M2) lvl = LVL_M1;
    else                  lvl = LVL_M2;
  end

  always_comb begin
    unique case (lvl)
      LVL_M2:  fb_o = -(FQ <<< 1);
      LVL_M1:  fb_o = -FQ;
      LVL_P1:  fb_o = FQ;
      LVL_P2:  fb_o = FQ <<< 1;
      default: fb_o = '0;
    endcase
  end

  assign code_o = lvl;
endmodule

// File: rtl/dsm5_loop.sv
module dsm5_loop #(
  parameter int unsigned DW = 18,
  parameter int unsigned IW = 24,
  parameter int unsigned UW = 27
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 mute_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW:0]   fb_i,
  output logic signed [UW-1:0] u_o
);
  localparam int unsigned NS = 3;
  localparam int unsigned SW = IW + 1;
  localparam logic signed [IW-1:0] SMAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic signed [IW-1:0] SMIN = {1'b1, {(IW-1){1'b0}}};

  logic signed [IW-1:0] st_q [NS];
  logic signed [IW-1:0] in_w [NS];

  for (genvar k = 0; k < NS; k++) begin : g_int
    logic signed [SW-1:0] sum_w;
    logic signed [IW-1:0] nxt_w;

    if (k == 0) begin : g_head
      assign in_w[k] = IW'(x_i) - IW'(fb_i);
    end else begin : g_tail
      assign in_w[k] = st_q[k-1];
    end

    assign sum_w = SW'(st_q[k]) + SW'(in_w[k]);
    always_comb begin
      if (sum_w > SW'(SMAX))      nxt_w = SMAX;
      else if (sum_w < SW'(SMIN)) nxt_w = SMIN;
      else                        nxt_w = sum_w[IW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     st_q[k] <= '0;
      else if (tick_i) st_q[k] <= mute_i ? '0 : nxt_w;
    end
  end

  // weights 3/2, 3/4, 1/8: triple NTF pole at 0.5
  assign u_o = UW'(st_q[0]) + UW'(st_q[0] >>> 1)
             + UW'(st_q[1] >>> 1) + UW'(st_q[1] >>> 2)
             + UW'(st_q[2] >>> 3);

  p_mute_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mute_i) |=> (st_q[0] == '0 && st_q[1] == '0 && st_q[2] == '0));

  p_sat_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !mute_i && st_q[1] == SMAX && st_q[0] >= 0) |=> st_q[1] == SMAX);
endmodule

// File: rtl/dsm5_mod.sv
module dsm5_mod
  import dsm5_pkg::*;
#(
  parameter int unsigned DW       = DSM_DW,
  parameter int unsigned IW       = DSM_IW,
  parameter int unsigned TICKS_HI = 8,
  parameter int unsigned TICKS_LO = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] sample_i,
  input  logic                 sample_valid_i,
  input  logic                 tick_i,
  input  logic                 ratio_384_i,
  input  logic                 mute_i,
  output logic [DSM_LW-1:0]    level_o,
  output logic                 level_valid_o
);
  localparam int unsigned UW = IW + 3;

  logic signed [DW-1:0] x_w;
  logic signed [DW:0]   fb_w;
  logic signed [UW-1:0] u_w;
  logic [DSM_LW-1:0]    code_w;
  logic [DSM_LW-1:0]    level_q;
  logic                 valid_q;

  dsm5_frame #(.DW(DW), .TICKS_HI(TICKS_HI), .TICKS_LO(TICKS_LO)) i_frame (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .tick_i, .ratio_384_i,
    .x_o (x_w)
  );

  dsm5_loop #(.DW(DW), .IW(IW), .UW(UW)) i_loop (
    .clk_i, .rst_ni, .tick_i, .mute_i,
    .x_i  (x_w),
    .fb_i (fb_w),
    .u_o  (u_w)
  );

  dsm5_quant #(.DW(DW), .UW(UW)) i_quant (
    .u_i    (u_w),
    .code_o (code_w),
    .fb_o   (fb_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= LVL_Z;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick_i;
      if (tick_i) level_q <= mute_i ? LVL_Z : code_w;
    end
  end

  assign level_o       = level_q;
  assign level_valid_o = valid_q;

  p_valid_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> level_valid_o);
  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !level_valid_o);
  p_level_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_o));
  p_level_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_valid_o |-> level_o <= 3'd4);
  p_mute_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mute_i) |=> level_o == 3'd2);
endmodule

// File: tb/test_dsm5_mod.sv
module test_dsm5_mod;
  localparam int NTAB = 8;
  localparam int SEG  = 384;
  localparam longint Q = 65536;
  localparam int TB_X [NTAB]   = '{0, 65536, -65536, 32768, -32768, 16384, 49152, -49152};
  localparam bit TB_R [NTAB]   = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam int TB_SUM [NTAB] = '{0, 384, -384, 192, -192, 96, 288, -288};

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic signed [17:0] sample_i = '0;
  logic               sample_valid_i = 1'b0;
  logic               tick_i = 1'b0;
  logic               ratio_384_i = 1'b1;
  logic               mute_i = 1'b0;
  logic [2:0]         level_o;
  logic               level_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  longint m_i1, m_i2, m_i3, m_pend, m_act;
  int m_ph, m_code;
  int seg_bad, seg_act, seg_exp, last_code;

  always #4 clk = ~clk;

  dsm5_mod i_dsm5_mod (
    .clk_i(clk), .rst_ni, .sample_i, .sample_valid_i, .tick_i,
    .ratio_384_i, .mute_i, .level_o, .level_valid_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat24(input longint a);
    if (a > 64'sd8388607) return 64'sd8388607;
    if (a < -64'sd8388608) return -64'sd8388608;
    return a;
  endfunction

  function automatic int qz(input longint u);
    if (u >= 98304) return 4;
    if (u >= 32768) return 3;
    if (u >= -32768) return 2;
    if (u >= -98304) return 1;
    return 0;
  endfunction

  task automatic m_reset();
    m_i1 = 0; m_i2 = 0; m_i3 = 0; m_pend = 0; m_act = 0; m_ph = 0; m_code = 2;
  endtask

  task automatic m_step();
    longint x, u, v, n1, n2, n3;
    int last;
    x = (m_ph == 0) ? m_pend : m_act;
    if (m_ph == 0) m_act = m_pend;
    if (mute_i) begin
      m_code = 2; m_i1 = 0; m_i2 = 0; m_i3 = 0;
    end else begin
      u = m_i1 + (m_i1 >>> 1) + (m_i2 >>> 1) + (m_i2 >>> 2) + (m_i3 >>> 3);
      m_code = qz(u);
      v = longint'(m_code - 2) * Q;
      n1 = sat24(m_i1 + x - v);
      n2 = sat24(m_i2 + m_i1);
      n3 = sat24(m_i3 + m_i2);
      m_i1 = n1; m_i2 = n2; m_i3 = n3;
    end
    last = ratio_384_i ? 5 : 7;
    m_ph = (m_ph >= last) ? 0 : m_ph + 1;
  endtask

  task automatic seg_start();
    seg_bad = 0; seg_act = 0; seg_exp = 0;
  endtask

  task automatic note(input int a, input int e);
    if (seg_bad == 0) begin seg_act = a; seg_exp = e; end
    seg_bad++;
  endtask

  task automatic tick();
    @(negedge clk);
    if (level_valid_o !== 1'b0) note(int'(level_valid_o), 0);
    tick_i = 1'b1;
    @(posedge clk);
    m_step();
    @(negedge clk);
    tick_i = 1'b0;
    if (level_valid_o !== 1'b1) note(int'(level_valid_o), 1);
    last_code = int'(level_o);
    if (last_code != m_code) note(last_code, m_code);
  endtask

  task automatic strobe(input int val);
    @(negedge clk);
    sample_i = 18'(val);
    sample_valid_i = 1'b1;
    @(posedge clk);
    m_pend = longint'(val);
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    m_reset();
    repeat (2) @(negedge clk);
    chk(level_o == 3'd2, "R1 level in reset", level_o, 2);
    chk(level_valid_o == 1'b0, "R1 valid in reset", level_valid_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic frame_delay(input bit r, input int exp_n, input string req);
    int n;
    bit seen;
    ratio_384_i = r;
    mute_i = 1'b0;
    do_reset();
    seg_start();
    repeat (3) tick();
    strobe(65536);
    n = 0; seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      tick();
      n++;
      if (last_code != 2) seen = 1'b1;
    end
    chk(n == exp_n, req, n, exp_n);
    // loop sum lands exactly on the upper threshold: R3
    chk(last_code == 4, "R3 threshold 98304 gives code 4", last_code, 4);
    chk(seg_bad == 0, "R7 reference stream", seg_act, seg_exp);
  endtask

  initial begin
    int sum, nz;
    m_reset();
    do_reset();

    // R4: zero input from reset stays at mid-scale
    seg_start(); nz = 0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (last_code != 2) nz++;
    end
    chk(nz == 0, "R4 zero input codes", nz, 0);
    chk(seg_bad == 0, "R2 strobe timing and stream", seg_act, seg_exp);

    // R7/R8: sample takes effect only at the next frame start
    frame_delay(1'b1, 5, "R8 six-tick frame delay");
    frame_delay(1'b0, 7, "R8 eight-tick frame delay");

    // table: density and reference stream per input level
    for (int e = 0; e < NTAB; e++) begin
      ratio_384_i = TB_R[e];
      strobe(TB_X[e]);
      mute_i = 1'b1;
      seg_start(); nz = 0;
      for (int k = 0; k < 8; k++) begin
        tick();
        if (last_code != 2) nz++;
      end
      chk(nz == 0, "R9 mute codes", nz, 0);
      mute_i = 1'b0;
      sum = 0;
      for (int k = 0; k < SEG; k++) begin
        tick();
        sum += last_code - 2;
      end
      chk(seg_bad == 0, "R5 reference stream", seg_act, seg_exp);
      chk(sum >= TB_SUM[e] - 8 && sum <= TB_SUM[e] + 8, "R10 code density", sum, TB_SUM[e]);
    end

    // R6: full-scale inputs drive integrators into their limits
    ratio_384_i = 1'b1;
    do_reset();
    strobe(-131072);
    seg_start(); nz = 0;
    for (int k = 0; k < 600; k++) begin
      tick();
      if (last_code > 4) nz++;
    end
    chk(seg_bad == 0, "R6 negative saturation stream", seg_act, seg_exp);
    strobe(131071);
    seg_start();
    for (int k = 0; k < 400; k++) begin
      tick();
      if (last_code > 4) nz++;
    end
    chk(seg_bad == 0, "R6 positive recovery stream", seg_act, seg_exp);
    chk(nz == 0, "R3 code range", nz, 0);

    // R1: reset while loaded returns everything to zero
    do_reset();
    seg_start(); nz = 0;
    for (int k = 0; k < 16; k++) begin
      tick();
      if (last_code != 2) nz++;
    end
    chk(nz == 0, "R1 cleared after reset", nz, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule